// File: doc/BRIEF.md
# Core Power-Domain Bring-Up Sequencer

This block powers up one secondary processor core and lets it out of reset. A requester pulses `req_i` with a core index of 0 or 1. The sequencer then changes that core's 32-bit power-control word one step at a time, in a fixed order. After each step that has a status bit, it waits for the power switches to report that status on the core's status word. The last action sets the core's active-low reset-release bit in a shared core-control word. If that bit is already set, the whole sequence is skipped.

The handshake is `req_i` / `busy_o` / `done_o` / `err_o`. Each status wait has a cycle limit taken from `tmo_limit_i`. When the limit runs out, the sequence stops. Every control bit keeps the value it had, the core stays in reset, and `err_o` pulses with the number of the failing step on `err_step_o`. Only one bring-up runs at a time.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset, each core's control word is 0x0000_8F04 (logic clamp bit 15 set, memory power-down field 11:8 all ones, memory clamp bit 2 set, all power-on and power-good bits clear). The shared word is 0x0000_2000, so core 0 is released (bit 13) and core 1 is held (bit 14). `busy_o`, `done_o` and `err_o` are low.
- R2: A request for core x whose release bit (13+x) is already set changes no control word. `done_o` pulses in the cycle after the accepting edge, and `busy_o` stays low.
- R3: Step 1 sets logic power-on bits 21:20. The sequencer then waits until status bits 29:28 both read 1.
- R4: Step 2 sets logic power-good bits 17:16 while bits 21:20 stay set. The sequencer then waits until status bits 25:24 both read 1.
- R5: Step 3 clears the logic clamp (bit 15). Step 4 clears the memory power-down field (bits 11:8). Step 5 sets memory power-on (bit 1) and waits for status bit 5. Each of these changes appears as a separate change of the control word, in that order.
- R6: Step 6 sets memory power-good (bit 0) and waits for status bit 4. Step 7 then clears the memory clamp (bit 2). A full bring-up from reset leaves the word at 0x0033_0003.
- R7: Release bit 13+x is set only after the core's memory clamp is clear. It is set in the same cycle that `done_o` pulses.
- R8: All bits of the shared word other than the release bits keep their value. The control word of a core that is not being sequenced never changes.
- R9: A request that arrives while `busy_o` is high is ignored. It produces no done or error pulse.
- R10: With limit T, a status wait that never succeeds raises `err_o` T+2 edges after the accepting edge when the stall is in step 1. `err_step_o` holds the step number (1, 2, 5 or 6). Control bits keep their values and the release bit stays clear.
- R11: `busy_o` is high from the cycle after a sequence is accepted until the cycle in which `done_o` or `err_o` pulses. It is low in that cycle. `done_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Bring-up request, sampled while idle |
| req_core_i | input | CORE_W | Index of the core to bring up |
| tmo_limit_i | input | TMO_W | Cycle limit for each status wait |
| stat_i | input | NUM_CORES*32 | Status word per core from the power switches |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: sequence finished or skipped |
| err_o | output | 1 | One-cycle pulse: a status wait timed out |
| err_step_o | output | 3 | Step number of the last timeout |
| pwr_ctrl_o | output | NUM_CORES*32 | Power-control word per core |
| core_ctrl_o | output | 32 | Shared word holding the active-low reset-release bits |

## Verification
The checker assumes several things about the environment. A status bit rises only after the matching control bit has been set. The core index is always below NUM_CORES. The cycle limit stays fixed while a sequence runs. The bench enforces these assumptions with a power-switch model that copies each core's control bits into its status word one cycle later. It can hold back one chosen status step to force a timeout. It uses only indices 0 and 1, and it changes the limit only while the block is idle.

// File: rtl/core_pwr_pkg.sv
package core_pwr_pkg;

  localparam int WORD_W = 32;

  // control word fields
  localparam int LON_LO    = 20;  // logic power-on, 2 bits
  localparam int LGOOD_LO  = 16;  // logic power-good, 2 bits
  localparam int LCLAMP    = 15;
  localparam int MPD_LO    = 8;   // memory power-down field
  localparam int MPD_W     = 4;
  localparam int MCLAMP    = 2;
  localparam int MON       = 1;
  localparam int MGOOD     = 0;

  // status word fields
  localparam int LON_ST_LO   = 28;
  localparam int LGOOD_ST_LO = 24;
  localparam int MON_ST      = 5;
  localparam int MGOOD_ST    = 4;

  localparam logic [WORD_W-1:0] CTRL_RST_WORD =
      (WORD_W'(1) << LCLAMP) | (WORD_W'((1 << MPD_W) - 1) << MPD_LO) |
      (WORD_W'(1) << MCLAMP);

  typedef enum logic [3:0] {
    ST_IDLE, ST_LON, ST_LON_W, ST_LGOOD, ST_LGOOD_W, ST_LCLAMP, ST_MPD,
    ST_MON, ST_MON_W, ST_MGOOD, ST_MGOOD_W, ST_MCLAMP, ST_REL
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_LON, OP_LGOOD, OP_LCLAMP, OP_MPD, OP_MON, OP_MGOOD, OP_MCLAMP
  } ctrl_op_e;

  typedef enum logic [1:0] {
    CHK_LON, CHK_LGOOD, CHK_MON, CHK_MGOOD
  } stat_chk_e;

endpackage

// File: rtl/cpw_step_timer.sv
module cpw_step_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != limit_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = (cnt_q == limit_i);

endmodule

// File: rtl/cpw_stat_mux.sv
module cpw_stat_mux
  import core_pwr_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int CORE_W    = 1
) (
  input  logic [NUM_CORES*WORD_W-1:0] stat_i,
  input  logic [CORE_W-1:0]           core_i,
  input  stat_chk_e                   chk_i,
  output logic                        ok_o
);

  logic [WORD_W-1:0] word;
  logic              unused_stat;

  always_comb begin
    word = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (CORE_W'(c) == core_i) word = stat_i[c*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    unique case (chk_i)
      CHK_LON:   ok_o = &word[LON_ST_LO +: 2];
      CHK_LGOOD: ok_o = &word[LGOOD_ST_LO +: 2];
      CHK_MON:   ok_o = word[MON_ST];
      CHK_MGOOD: ok_o = word[MGOOD_ST];
      default:   ok_o = 1'b0;
    endcase
  end

  assign unused_stat = ^word;

endmodule

// File: rtl/cpw_ctrl_regs.sv
module cpw_ctrl_regs
  import core_pwr_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int CORE_W    = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  ctrl_op_e                    op_i,
  input  logic [CORE_W-1:0]           core_i,
  output logic [NUM_CORES*WORD_W-1:0] ctrl_o
);

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= CTRL_RST_WORD;
      end else if (core_i == CORE_W'(g)) begin
        case (op_i)
          OP_LON:    word_q[LON_LO +: 2]      <= 2'b11;
          OP_LGOOD:  word_q[LGOOD_LO +: 2]    <= 2'b11;
          OP_LCLAMP: word_q[LCLAMP]           <= 1'b0;
          OP_MPD:    word_q[MPD_LO +: MPD_W]  <= '0;
          OP_MON:    word_q[MON]              <= 1'b1;
          OP_MGOOD:  word_q[MGOOD]            <= 1'b1;
          OP_MCLAMP: word_q[MCLAMP]           <= 1'b0;
          default:   word_q                   <= word_q;
        endcase
      end
    end

    assign ctrl_o[g*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/cpw_seq_fsm.sv
module cpw_seq_fsm
  import core_pwr_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int CORE_W    = 1,
  parameter int REL_BASE  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [CORE_W-1:0] req_core_i,
  input  logic              stat_ok_i,
  input  logic              tmo_i,
  output ctrl_op_e          op_o,
  output stat_chk_e         chk_o,
  output logic              wait_o,
  output logic [CORE_W-1:0] core_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2:0]        err_step_o,
  output logic [WORD_W-1:0] core_ctrl_o
);

  localparam logic [WORD_W-1:0] REL_RST = WORD_W'(1) << REL_BASE;

  seq_state_e        state_q;
  logic [CORE_W-1:0] core_q;
  logic              busy_q, done_q, err_q;
  logic [2:0]        step_q;
  logic [WORD_W-1:0] rel_q;
  logic [2:0]        wait_step;

  always_comb begin
    op_o      = OP_NONE;
    chk_o     = CHK_LON;
    wait_o    = 1'b0;
    wait_step = 3'd0;
    unique case (state_q)
      ST_LON:     op_o = OP_LON;
      ST_LGOOD:   op_o = OP_LGOOD;
      ST_LCLAMP:  op_o = OP_LCLAMP;
      ST_MPD:     op_o = OP_MPD;
      ST_MON:     op_o = OP_MON;
      ST_MGOOD:   op_o = OP_MGOOD;
      ST_MCLAMP:  op_o = OP_MCLAMP;
      ST_LON_W:   begin wait_o = 1'b1; chk_o = CHK_LON;   wait_step = 3'd1; end
      ST_LGOOD_W: begin wait_o = 1'b1; chk_o = CHK_LGOOD; wait_step = 3'd2; end
      ST_MON_W:   begin wait_o = 1'b1; chk_o = CHK_MON;   wait_step = 3'd5; end
      ST_MGOOD_W: begin wait_o = 1'b1; chk_o = CHK_MGOOD; wait_step = 3'd6; end
      default:    op_o = OP_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      core_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      step_q  <= 3'd0;
      rel_q   <= REL_RST;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (wait_o && !stat_ok_i && tmo_i) begin
        err_q   <= 1'b1;
        step_q  <= wait_step;
        busy_q  <= 1'b0;
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (req_i) begin
            core_q <= req_core_i;
            if (rel_q[REL_BASE + int'(req_core_i)]) begin
              done_q <= 1'b1;
            end else begin
              busy_q  <= 1'b1;
              state_q <= ST_LON;
            end
          end
          ST_LON:     state_q <= ST_LON_W;
          ST_LON_W:   if (stat_ok_i) state_q <= ST_LGOOD;
          ST_LGOOD:   state_q <= ST_LGOOD_W;
          ST_LGOOD_W: if (stat_ok_i) state_q <= ST_LCLAMP;
          ST_LCLAMP:  state_q <= ST_MPD;
          ST_MPD:     state_q <= ST_MON;
          ST_MON:     state_q <= ST_MON_W;
          ST_MON_W:   if (stat_ok_i) state_q <= ST_MGOOD;
          ST_MGOOD:   state_q <= ST_MGOOD_W;
          ST_MGOOD_W: if (stat_ok_i) state_q <= ST_MCLAMP;
          ST_MCLAMP:  state_q <= ST_REL;
          ST_REL: begin
            rel_q[REL_BASE + int'(core_q)] <= 1'b1;
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
          default:    state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign core_o      = core_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign err_step_o  = step_q;
  assign core_ctrl_o = rel_q;

endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import core_pwr_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int TMO_W     = 16,
  parameter int REL_BASE  = 13,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_i,
  input  logic [CORE_W-1:0]           req_core_i,
  input  logic [TMO_W-1:0]            tmo_limit_i,
  input  logic [NUM_CORES*WORD_W-1:0] stat_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        err_o,
  output logic [2:0]                  err_step_o,
  output logic [NUM_CORES*WORD_W-1:0] pwr_ctrl_o,
  output logic [WORD_W-1:0]           core_ctrl_o
);

  ctrl_op_e          op;
  stat_chk_e         chk;
  logic              wait_act, stat_ok, tmo;
  logic [CORE_W-1:0] core_sel;

  cpw_seq_fsm #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .REL_BASE(REL_BASE)) u_fsm (
    .clk(clk), .rst(rst), .req_i(req_i), .req_core_i(req_core_i),
    .stat_ok_i(stat_ok), .tmo_i(tmo), .op_o(op), .chk_o(chk), .wait_o(wait_act),
    .core_o(core_sel), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .err_step_o(err_step_o), .core_ctrl_o(core_ctrl_o)
  );

  cpw_ctrl_regs #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_regs (
    .clk(clk), .rst(rst), .op_i(op), .core_i(core_sel), .ctrl_o(pwr_ctrl_o)
  );

  cpw_stat_mux #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_stat (
    .stat_i(stat_i), .core_i(core_sel), .chk_i(chk), .ok_o(stat_ok)
  );

  cpw_step_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst(rst), .run_i(wait_act), .limit_i(tmo_limit_i), .expired_o(tmo)
  );

endmodule

// File: rtl/cpw_seq_chk.sv
module cpw_seq_chk #(
  parameter int NUM_CORES = 2,
  parameter int REL_BASE  = 13
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    busy_o,
  input logic                    done_o,
  input logic                    err_o,
  input logic [NUM_CORES*32-1:0] pwr_ctrl_o,
  input logic [31:0]             core_ctrl_o
);

  localparam logic [31:0] REL_MASK = ((32'd1 << NUM_CORES) - 32'd1) << REL_BASE;

  // R11
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, err_o}));

  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o || err_o) |-> !busy_o);

  // R10
  err_from_busy_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(busy_o));

  // R8
  other_bits_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(core_ctrl_o & ~REL_MASK));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    // R7
    rel_after_clamp_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(core_ctrl_o[REL_BASE+g]) |-> (!pwr_ctrl_o[g*32+2] && done_o));

    // R7
    rel_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      $past(core_ctrl_o[REL_BASE+g]) |-> core_ctrl_o[REL_BASE+g]);

    // R4
    lgood_keeps_on_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pwr_ctrl_o[g*32+16]) |-> (pwr_ctrl_o[g*32+20 +: 2] == 2'b11));

    // R5
    mon_after_pd_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pwr_ctrl_o[g*32+1]) |-> (pwr_ctrl_o[g*32+8 +: 4] == 4'h0 && !pwr_ctrl_o[g*32+15]));
  end

endmodule

bind core_pwr_seq cpw_seq_chk #(.NUM_CORES(NUM_CORES), .REL_BASE(REL_BASE)) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .pwr_ctrl_o(pwr_ctrl_o), .core_ctrl_o(core_ctrl_o)
);

// File: tb/core_pwr_seq_tb.sv
module core_pwr_seq_tb;

  typedef struct {
    bit          is_err;
    int          step;
    logic [31:0] arm;
    logic [31:0] ctrl;
    int          core;
    int          lat;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst;
  logic        req;
  logic [0:0]  req_core;
  logic [15:0] tmo_limit;
  logic [63:0] stat;
  logic        busy, done, err;
  logic [2:0]  err_step;
  logic [63:0] pwr_ctrl;
  logic [31:0] core_ctrl;

  int   n_chk = 0;
  int   n_err = 0;
  int   cyc = 0;
  int   acc_cyc = 0;
  bit   blk1 = 0, blk2 = 0, blk5 = 0, blk6 = 0;
  exp_t q[$];

  logic [31:0] seq_w [0:7] = '{32'h0000_8F04, 32'h0030_8F04, 32'h0033_8F04, 32'h0033_0F04,
                               32'h0033_0004, 32'h0033_0006, 32'h0033_0007, 32'h0033_0003};
  string seq_tag [0:7] = '{"R1", "R3", "R4", "R5", "R5", "R5", "R6", "R6"};

  always #2.5 clk = ~clk;

  core_pwr_seq u_dut (
    .clk(clk), .rst(rst), .req_i(req), .req_core_i(req_core), .tmo_limit_i(tmo_limit),
    .stat_i(stat), .busy_o(busy), .done_o(done), .err_o(err), .err_step_o(err_step),
    .pwr_ctrl_o(pwr_ctrl), .core_ctrl_o(core_ctrl)
  );

  // power-switch model: status follows control one cycle later
  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int c = 0; c < 2; c++) begin
      logic [31:0] w;
      logic [31:0] s;
      w = pwr_ctrl[c*32 +: 32];
      s = '0;
      s[29:28] = blk1 ? 2'b00 : w[21:20];
      s[25:24] = blk2 ? 2'b00 : w[17:16];
      s[5]     = blk5 ? 1'b0 : w[1];
      s[4]     = blk6 ? 1'b0 : w[0];
      stat[c*32 +: 32] <= s;
    end
  end

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && (done || err)) begin
      if (q.size() == 0) begin
        chk("R9", "unexpected completion pulse", {30'd0, done, err}, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.is_err ? "R10" : "R11", "error flag", {31'd0, err}, {31'd0, e.is_err});
        if (e.is_err) chk("R10", "step code", {29'd0, err_step}, e.step);
        chk("R7", "shared word", core_ctrl, e.arm);
        chk(e.is_err ? "R10" : "R6", "control word", pwr_ctrl[e.core*32 +: 32], e.ctrl);
        chk("R11", "busy at completion", {31'd0, busy}, 32'd0);
        if (e.lat >= 0) chk(e.is_err ? "R10" : "R2", "latency", cyc - acc_cyc, e.lat);
      end
    end
  end

  // ordering monitor for core 1
  logic [31:0] prev1;
  always @(negedge clk) begin
    if (rst) begin
      prev1 <= pwr_ctrl[63:32];
    end else begin
      if (pwr_ctrl[63:32] !== prev1) begin
        int idx;
        idx = -1;
        for (int k = 0; k < 7; k++) if (seq_w[k] === prev1) idx = k;
        if (idx < 0) chk("R5", "step order", prev1, seq_w[0]);
        else chk(seq_tag[idx+1], "step order", pwr_ctrl[63:32], seq_w[idx+1]);
      end
      prev1 <= pwr_ctrl[63:32];
    end
  end

  task automatic start(int core, bit exp_busy);
    @(negedge clk);
    req = 1'b1;
    req_core = core[0:0];
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    acc_cyc = cyc;
    chk("R11", "busy after accept", {31'd0, busy}, {31'd0, exp_busy});
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_ev(bit is_err, int step, logic [31:0] arm, logic [31:0] ctrl,
                           int core, int lat);
    exp_t e;
    e.is_err = is_err; e.step = step; e.arm = arm; e.ctrl = ctrl; e.core = core; e.lat = lat;
    q.push_back(e);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; req = 1'b0; req_core = '0; tmo_limit = 16'd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "core0 word", pwr_ctrl[31:0], 32'h0000_8F04);
    chk("R1", "core1 word", pwr_ctrl[63:32], 32'h0000_8F04);
    chk("R1", "shared word", core_ctrl, 32'h0000_2000);
    chk("R1", "busy/done/err", {29'd0, busy, done, err}, 32'd0);

    // R2 skip for already released core 0
    expect_ev(0, 0, 32'h0000_2000, 32'h0000_8F04, 0, 0);
    start(0, 0);
    drain();

    // R10 timeout in step 1, limit 5 and limit 0
    blk1 = 1;
    tmo_limit = 16'd5;
    expect_ev(1, 1, 32'h0000_2000, 32'h0030_8F04, 1, 7);
    start(1, 1);
    drain();
    tmo_limit = 16'd0;
    expect_ev(1, 1, 32'h0000_2000, 32'h0030_8F04, 1, 2);
    start(1, 1);
    drain();

    // R10 timeout in step 5
    blk1 = 0; blk5 = 1; tmo_limit = 16'd3;
    repeat (2) @(negedge clk);
    expect_ev(1, 5, 32'h0000_2000, 32'h0033_0006, 1, -1);
    start(1, 1);
    drain();

    // R10 timeout in step 6
    blk5 = 0; blk6 = 1; tmo_limit = 16'd1;
    repeat (2) @(negedge clk);
    expect_ev(1, 6, 32'h0000_2000, 32'h0033_0007, 1, -1);
    start(1, 1);
    drain();

    // R6/R7 completion; R9 request during busy is ignored
    blk6 = 0; tmo_limit = 16'd4;
    repeat (2) @(negedge clk);
    expect_ev(0, 0, 32'h0000_6000, 32'h0033_0003, 1, -1);
    start(1, 1);
    @(negedge clk);
    req = 1'b1; req_core = 1'b0;
    @(negedge clk);
    req = 1'b0;
    drain();

    // R2 skip for core 1, now released
    expect_ev(0, 0, 32'h0000_6000, 32'h0033_0003, 1, 0);
    start(1, 0);
    drain();

    // R8 untouched core and shared word
    chk("R8", "core0 word untouched", pwr_ctrl[31:0], 32'h0000_8F04);
    chk("R8", "shared word", core_ctrl, 32'h0000_6000);
    chk("R9", "pending events", q.size(), 32'd0);

    summary();
    $finish;
  end

endmodule